// File: doc/BRIEF.md
# Bus Data-Beat Termination Sequencer

This block sits on the master side of a 64-bit processor bus whose address and data phases are split. Once an address phase has been issued, a one-cycle start pulse hands the sequencer the transfer's byte count, a burst flag and the width of the target port. The sequencer then counts the physical data beats the transfer needs on that port. It pulses a beat-valid strobe toward the internal requester on every beat, and a termination strobe only on the beat that closes a logical transfer unit.

A single (non-burst) transfer is one logical unit, however many physical beats a narrow port splits it into. A burst is four logical units of one full bus word (8 bytes) each, and every one of them ends with its own termination strobe. Beats advance only on cycles in which the slave reports ready. A transfer-error input aborts the transfer at once and reports a bus error. Either way, a one-cycle done pulse marks the return to idle.

Top module: `beat_term_seq`

## Requirements
- R1: While reset is high, and in the cycle after it, beat_vld_o, term_ack_o, done_o and bus_err_o are 0 and beat_idx_o is 0.
- R2: The port code selects the port width: 0 = 8 bytes, 1 = 4 bytes, 2 = 2 bytes, 3 = 1 byte. A non-burst transfer of S bytes (size_i = S, 0..31) produces exactly max(1, floor(S / port bytes)) beat_vld_o pulses.
- R3: On a non-burst transfer, term_ack_o is high only on the last beat. For example, 16 bytes on a 4-byte port gives three beats without termination and a fourth beat with both strobes.
- R4: A burst ignores size_i and moves four units of 8 bytes. Each unit takes P = max(1, 8 / port bytes) beats, so the burst has 4·P beats, and term_ack_o is high on every P-th beat.
- R5: term_ack_o is never high without beat_vld_o.
- R6: Every output appears one cycle after the clock edge that samples its inputs. A beat occurs only in the cycle after an edge that sampled rdy_i high while busy. An edge with rdy_i low yields no beat, and the position within the transfer is held.
- R7: beat_idx_o carries the beat's position within the transfer, 0 for the first beat and one higher for each beat after it.
- R8: done_o is high for exactly one cycle, together with the strobes of the final beat, and the block is then idle.
- R9: If err_i is sampled high while busy, the next cycle shows bus_err_o and done_o high and beat_vld_o low. The transfer ends. err_i takes priority over rdy_i.
- R10: start_i is ignored while a transfer is in progress. A start sampled in the cycle that shows done_o is accepted, and the accepting edge produces no beat.
- R11: Each new transfer restarts its beat position at 0, even after one that was aborted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle start of a transfer's data phase |
| size_i | input | SIZE_W | Byte count of a non-burst transfer |
| burst_i | input | 1 | Burst transfer (four full-word units) |
| port_i | input | 2 | Port width code (0=8, 1=4, 2=2, 3=1 bytes) |
| rdy_i | input | 1 | Slave ready; a beat advances when high |
| err_i | input | 1 | Transfer error; aborts the transfer |
| beat_vld_o | output | 1 | Data-valid strobe, one per physical beat |
| term_ack_o | output | 1 | Termination strobe for a logical unit |
| beat_idx_o | output | IDX_W | Position of the current beat in the transfer |
| done_o | output | 1 | One-cycle pulse when the transfer ends |
| bus_err_o | output | 1 | One-cycle pulse when the transfer was aborted |

## Verification
The assertions assume that rdy_i and err_i are clean synchronous levels and that start_i matters only while the block is idle. They place no constraint on inputs during a transfer, so the stimulus deliberately raises start_i and changes size_i, burst_i and port_i in mid-transfer to show that these are ignored. Ready is driven at random with several duty cycles, including always-ready runs. Errors are injected at chosen beat positions, sometimes on a cycle where ready is also high. The stimulus keeps size_i within its declared width and uses only the four port codes.

// File: rtl/beat_seq_pkg.sv
package beat_seq_pkg;
  typedef enum logic [1:0] {
    PORT_FULL    = 2'd0,
    PORT_HALF    = 2'd1,
    PORT_QUARTER = 2'd2,
    PORT_EIGHTH  = 2'd3
  } port_code_e;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/beat_plan.sv
module beat_plan #(
  parameter int DATA_BYTES = 8,
  parameter int BURST_LEN  = 4,
  parameter int SIZE_W     = 5,
  parameter int IDX_W      = 5,
  parameter int LOG_W      = 2
) (
  input  logic [SIZE_W-1:0] size_i,
  input  logic              burst_i,
  input  logic [1:0]        port_i,
  output logic [IDX_W-1:0]  phys_last_o,
  output logic [LOG_W-1:0]  log_last_o
);
  localparam int LOG_DB = $clog2(DATA_BYTES);
  localparam int BW     = IDX_W + 1;

  logic [BW-1:0] unit_bytes;
  logic [BW-1:0] per_unit;

  always_comb begin
    unit_bytes = burst_i ? BW'(DATA_BYTES) : BW'(size_i);
    per_unit   = unit_bytes >> (LOG_DB - int'(port_i));
    if (per_unit == '0)
      phys_last_o = '0;
    else
      phys_last_o = IDX_W'(per_unit - BW'(1));
    log_last_o = burst_i ? LOG_W'(BURST_LEN - 1) : '0;
  end
endmodule

// File: rtl/beat_counter.sv
module beat_counter #(
  parameter int IDX_W = 5,
  parameter int LOG_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             adv_i,
  input  logic [IDX_W-1:0] phys_last_i,
  input  logic [LOG_W-1:0] log_last_i,
  output logic             unit_end_o,
  output logic             xfer_end_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] phys_cnt, phys_lim;
  logic [LOG_W-1:0] log_cnt, log_lim;

  assign unit_end_o = (phys_cnt == phys_lim);
  assign xfer_end_o = unit_end_o && (log_cnt == log_lim);

  always_ff @(posedge clk) begin
    if (rst) begin
      phys_cnt <= '0;
      phys_lim <= '0;
      log_cnt  <= '0;
      log_lim  <= '0;
      idx_o    <= '0;
    end else if (load_i) begin
      phys_cnt <= '0;
      phys_lim <= phys_last_i;
      log_cnt  <= '0;
      log_lim  <= log_last_i;
      idx_o    <= '0;
    end else if (adv_i) begin
      idx_o <= idx_o + 1'b1;
      if (unit_end_o) begin
        phys_cnt <= '0;
        log_cnt  <= log_cnt + 1'b1;
      end else begin
        phys_cnt <= phys_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/beat_term_seq.sv
module beat_term_seq
  import beat_seq_pkg::*;
#(
  parameter int DATA_BYTES = 8,
  parameter int BURST_LEN  = 4,
  parameter int SIZE_W     = 5,
  localparam int SIZE_MAX  = (1 << SIZE_W) - 1,
  localparam int BURST_BYTES = BURST_LEN * DATA_BYTES,
  localparam int MAX_BEATS = (BURST_BYTES > SIZE_MAX) ? BURST_BYTES : SIZE_MAX,
  localparam int IDX_W     = $clog2(MAX_BEATS),
  localparam int LOG_W     = $clog2(BURST_LEN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              burst_i,
  input  logic [1:0]        port_i,
  input  logic              rdy_i,
  input  logic              err_i,
  output logic              beat_vld_o,
  output logic              term_ack_o,
  output logic [IDX_W-1:0]  beat_idx_o,
  output logic              done_o,
  output logic              bus_err_o
);
  seq_state_e       state_q;
  logic [IDX_W-1:0] phys_last;
  logic [LOG_W-1:0] log_last;
  logic             unit_end, xfer_end;
  logic [IDX_W-1:0] cur_idx;
  logic             accept, advance;

  assign accept  = (state_q == SEQ_IDLE) && start_i;
  assign advance = (state_q == SEQ_RUN) && rdy_i && !err_i;

  beat_plan #(
    .DATA_BYTES(DATA_BYTES), .BURST_LEN(BURST_LEN),
    .SIZE_W(SIZE_W), .IDX_W(IDX_W), .LOG_W(LOG_W)
  ) u_plan (
    .size_i(size_i), .burst_i(burst_i), .port_i(port_i),
    .phys_last_o(phys_last), .log_last_o(log_last)
  );

  beat_counter #(.IDX_W(IDX_W), .LOG_W(LOG_W)) u_cnt (
    .clk(clk), .rst(rst), .load_i(accept), .adv_i(advance),
    .phys_last_i(phys_last), .log_last_i(log_last),
    .unit_end_o(unit_end), .xfer_end_o(xfer_end), .idx_o(cur_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= SEQ_IDLE;
      beat_vld_o <= 1'b0;
      term_ack_o <= 1'b0;
      beat_idx_o <= '0;
      done_o     <= 1'b0;
      bus_err_o  <= 1'b0;
    end else begin
      beat_vld_o <= 1'b0;
      term_ack_o <= 1'b0;
      done_o     <= 1'b0;
      bus_err_o  <= 1'b0;
      if (accept) begin
        state_q <= SEQ_RUN;
      end else if (state_q == SEQ_RUN) begin
        if (err_i) begin
          bus_err_o <= 1'b1;
          done_o    <= 1'b1;
          state_q   <= SEQ_IDLE;
        end else if (rdy_i) begin
          beat_vld_o <= 1'b1;
          term_ack_o <= unit_end;
          beat_idx_o <= cur_idx;
          if (xfer_end) begin
            done_o  <= 1'b1;
            state_q <= SEQ_IDLE;
          end
        end
      end
    end
  end
endmodule

// File: rtl/beat_term_seq_chk.sv
module beat_term_seq_chk (
  input logic clk,
  input logic rst,
  input logic rdy_i,
  input logic err_i,
  input logic beat_vld_o,
  input logic term_ack_o,
  input logic done_o,
  input logic bus_err_o
);
  assert_term_has_vld_R5: assert property (@(posedge clk) disable iff (rst)
    term_ack_o |-> beat_vld_o);

  assert_no_beat_unready_R6: assert property (@(posedge clk) disable iff (rst)
    !rdy_i |=> !beat_vld_o);

  assert_err_prio_R9: assert property (@(posedge clk) disable iff (rst)
    err_i |=> !beat_vld_o);

  assert_err_ends_R9: assert property (@(posedge clk) disable iff (rst)
    bus_err_o |-> (done_o && !beat_vld_o));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done_o |=> (!done_o && !beat_vld_o));
endmodule

bind beat_term_seq beat_term_seq_chk u_chk (
  .clk(clk), .rst(rst), .rdy_i(rdy_i), .err_i(err_i),
  .beat_vld_o(beat_vld_o), .term_ack_o(term_ack_o),
  .done_o(done_o), .bus_err_o(bus_err_o)
);

// File: tb/sim_beat_term_seq.sv
`timescale 1ns/1ps
module sim_beat_term_seq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [4:0] size = '0;
  logic       burst = 1'b0;
  logic [1:0] port = '0;
  logic       rdy = 1'b0;
  logic       err = 1'b0;
  logic       vld, term, done, berr;
  logic [4:0] idx;
  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  beat_term_seq u0 (
    .clk(clk), .rst(rst), .start_i(start), .size_i(size), .burst_i(burst),
    .port_i(port), .rdy_i(rdy), .err_i(err), .beat_vld_o(vld),
    .term_ack_o(term), .beat_idx_o(idx), .done_o(done), .bus_err_o(berr)
  );

  function automatic int unit_beats(int sz, bit bu, int pc);
    int pb = 8 >> pc;
    int by = bu ? 8 : sz;
    int p  = by / pb;
    return (p == 0) ? 1 : p;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_xfer(int sz, bit bu, int pc, int rdy_pct, int err_at, bit noisy);
    int p   = unit_beats(sz, bu, pc);
    int tot = p * (bu ? 4 : 1);
    int n   = 0;
    bit fin = 0;
    @(negedge clk);
    start = 1'b1; size = 5'(sz); burst = bu; port = 2'(pc);
    rdy = ($urandom % 100) < rdy_pct; err = 1'b0;
    @(posedge clk); #1;
    chk("R10 accept edge vld", vld, 0);
    while (!fin) begin
      @(negedge clk);
      start = noisy ? (($urandom % 3) == 0) : 1'b0;
      if (start) begin
        size = 5'($urandom % 32); burst = 1'($urandom % 2); port = 2'($urandom % 4);
      end
      rdy = ($urandom % 100) < rdy_pct;
      err = (err_at >= 0 && n == err_at && ($urandom % 2) == 0);
      @(posedge clk); #1;
      if (err) begin
        chk("R9 bus_err", berr, 1);
        chk("R9 done", done, 1);
        chk("R9 vld", vld, 0);
        fin = 1;
      end else if (rdy) begin
        chk("R2 vld", vld, 1);
        if (bu) chk("R4 term", term, ((n + 1) % p) == 0);
        else    chk("R3 term", term, (n + 1) == tot);
        chk("R5 term implies vld", (!term) || vld, 1);
        chk("R7 idx", idx, n);
        chk("R8 done", done, (n + 1) == tot);
        n++;
        if (n == tot) fin = 1;
      end else begin
        chk("R6 hold vld", vld, 0);
        chk("R6 hold done", done, 0);
      end
    end
    start = 1'b0; rdy = 1'b0; err = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 vld", vld, 0); chk("R1 term", term, 0); chk("R1 done", done, 0);
    chk("R1 berr", berr, 0); chk("R1 idx", idx, 0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    chk("R1 after release vld", vld, 0);
    // directed corner cases
    run_xfer(16, 0, 1, 100, -1, 0);   // R3: 3 plain beats then terminating beat
    run_xfer(0, 1, 0, 100, -1, 0);    // R4: burst on full-width port
    run_xfer(5, 1, 3, 100, -1, 1);    // R4: burst on byte port, 32 beats, noisy start (R10)
    run_xfer(1, 0, 0, 40, -1, 0);     // R2: single byte, one beat
    run_xfer(0, 0, 2, 100, -1, 0);    // R2: size zero still one beat
    run_xfer(31, 0, 3, 50, -1, 1);    // R2: largest non-burst
    run_xfer(8, 1, 1, 100, 3, 0);     // R9: abort mid burst
    run_xfer(16, 0, 2, 70, -1, 0);    // R11: index restarts after abort
    // constrained random
    for (int k = 0; k < 300; k++) begin
      int sz  = $urandom % 32;
      bit bu  = 1'($urandom % 3 == 0);
      int pc  = $urandom % 4;
      int rp  = 20 + ($urandom % 81);
      int ea  = ($urandom % 5 == 0) ? int'($urandom % 4) : -1;
      run_xfer(sz, bu, pc, rp, ea, 1'($urandom % 2));
      if ($urandom % 2) begin
        @(posedge clk); #1;
        chk("R8 idle vld", vld, 0);
        chk("R8 idle done", done, 0);
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule